// File: doc/BRIEF.md
# Multi-Level Interrupt Entry Controller

This block decides when a processor with several interrupt priority levels leaves its current flow for an interrupt handler, and performs that entry. It holds a software-writable pending vector, an enable vector, a table that assigns interrupt lines to levels, and the processor status word (current interrupt level, exception-mode flag, user-mode flag). It also holds one saved-PC register per level, one saved-status register per level from 2 upward, an exception-cause register, an optional double-exception PC register and a runtime vector base. External level-sensitive lines are ORed into the pending vector. The highest level that has a line which is pending, enabled and mapped to it is the candidate level. The candidate is taken only when it is strictly above the current effective level.

A level above 1 saves the PC and status into that level's registers, raises the status level and jumps to a per-level vector. A level-1 interrupt becomes a general exception with a fixed cause code. The exception goes to the kernel, user or double-exception vector, depending on the user and exception-mode flags. Every vector is moved by the difference between the runtime base and the default base. A wait-for-interrupt request loads a new status level. If nothing can be taken at that level the core halts, and it wakes on the first cycle in which an interrupt becomes acceptable.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the status word is zero (level 0, exception mode clear, user mode clear), `taken`, `halted`, `pend_level` and `redirect_pc` are 0, the pending and enable vectors are clear, and the vector base equals its default.
- R2: `pend_level` shows the highest level L in 1..NUM_LEVELS for which (mask of L) AND (pending OR `irq_lines`) AND enable is nonzero, or 0 when there is none. Writing a table entry for level 0 or for a level above NUM_LEVELS has no effect.
- R3: A candidate level is taken only if it is strictly greater than the effective current level. The effective level is the status level, raised to EXCM_LVL (default 1) while exception mode is set. An equal or lower level causes no entry.
- R4: Taking a level L above 1 stores `core_pc` in saved PC L and the old status in saved status L, sets the status level to L, and sets exception mode. `taken` is high for exactly the cycle after the deciding clock edge.
- R5: With the default base, the vector for level L is DEF_VBASE + 0x180 + 0x40*L. The kernel vector is DEF_VBASE + 0x300, the user vector DEF_VBASE + 0x340 and the double-exception vector DEF_VBASE + 0x3C0.
- R6: Taking level 1 with exception mode clear writes cause code 4 and stores `core_pc` in saved PC 1. It jumps to the user vector if user mode is set and to the kernel vector otherwise. It sets exception mode and leaves the status level unchanged.
- R7: Taking level 1 with exception mode already set (possible only when EXCM_LVL is 0) writes cause code 4 and jumps to the double-exception vector. With HAS_DEPC it stores `core_pc` in `depc` and leaves saved PC 1 unchanged.
- R8: The pending and enable vectors have separate write ports, and a write to one leaves the other unchanged. `irq_lines` take part in the candidate choice without being stored.
- R9: A wait request writes `wfi_level` into the status level and causes no entry on that edge. `halted` then goes high if no candidate exceeds the new effective level, and stays low otherwise.
- R10: While halted, the first cycle with an acceptable candidate clears `halted` and performs the entry on the same edge.
- R11: With relocation enabled, every vector is (default vector − DEF_VBASE + runtime base), and the runtime base is written through `vbase_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | NUM_IRQ | Level-sensitive interrupt lines, ORed into the pending vector |
| set_we | input | 1 | Pending-vector write enable |
| set_wdata | input | NUM_IRQ | Pending-vector write value |
| en_we | input | 1 | Enable-vector write enable |
| en_wdata | input | NUM_IRQ | Enable-vector write value |
| mask_we | input | 1 | Level table write enable |
| mask_lvl | input | LVL_W | Level whose table entry is written |
| mask_wdata | input | NUM_IRQ | Lines assigned to that level |
| vbase_we | input | 1 | Runtime vector base write enable |
| vbase_wdata | input | ADDR_W | Runtime vector base value |
| ps_we | input | 1 | Status word write enable |
| ps_wlevel | input | 4 | Status level to write |
| ps_wexcm | input | 1 | Exception-mode flag to write |
| ps_wum | input | 1 | User-mode flag to write |
| core_pc | input | ADDR_W | PC to save on entry |
| wfi_req | input | 1 | Wait-for-interrupt request |
| wfi_level | input | 4 | Status level set by the wait request |
| rd_lvl | input | LVL_W | Selects the saved PC and status shown on the read outputs |
| taken | output | 1 | Entry strobe, one cycle |
| redirect_pc | output | ADDR_W | Handler address of the latest entry |
| halted | output | 1 | Core waiting for an interrupt |
| pend_level | output | LVL_W | Current candidate level |
| ps_level | output | 4 | Status level |
| ps_excm | output | 1 | Exception-mode flag |
| ps_um | output | 1 | User-mode flag |
| exc_cause | output | 6 | Exception-cause register |
| depc | output | ADDR_W | Double-exception saved PC |
| rd_epc | output | ADDR_W | Saved PC of level `rd_lvl` |
| rd_eps | output | 6 | Saved status of level `rd_lvl` as {um, excm, level[3:0]}, 0 for level 1 |

## Verification
A wait request and an acceptable interrupt can arrive on the same edge. The bench provokes this by holding a level-3 interrupt pending under a status level of 3 and then issuing a wait request that drops the level to 0. The wait request must win that edge: the level becomes 0, no entry is made and `halted` stays low. The entry must then follow one edge later. The opposite case is also checked. A wait request at a level that masks the pending interrupt must halt the core, and raising a higher line must wake and enter on a single edge.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   localparam int PS_LVL_W = 4;
   localparam int PS_W     = PS_LVL_W + 2;
   localparam int CAUSE_W  = 6;

   localparam logic [CAUSE_W-1:0] CAUSE_LEVEL1 = 6'd4;

   typedef struct packed {
      logic                um;
      logic                excm;
      logic [PS_LVL_W-1:0] lvl;
   } ps_t;

   typedef enum logic [1:0] {
      ENT_NONE = 2'd0,
      ENT_HIGH = 2'd1,
      ENT_LOW  = 2'd2
   } entry_e;

   // level that incoming interrupts must exceed
   function automatic logic [PS_LVL_W-1:0] eff_level(
      input logic [PS_LVL_W-1:0] lvl,
      input logic                excm,
      input logic [PS_LVL_W-1:0] excm_lvl
   );
      return (excm && (excm_lvl > lvl)) ? excm_lvl : lvl;
   endfunction

endpackage

// File: rtl/irq_pend_unit.sv
module irq_pend_unit #(
   parameter int NUM_IRQ    = 8,
   parameter int NUM_LEVELS = 4,
   parameter int LVL_W      = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_lines,
   input  logic               set_we,
   input  logic [NUM_IRQ-1:0] set_wdata,
   input  logic               en_we,
   input  logic [NUM_IRQ-1:0] en_wdata,
   input  logic               mask_we,
   input  logic [LVL_W-1:0]   mask_lvl,
   input  logic [NUM_IRQ-1:0] mask_wdata,
   output logic [LVL_W-1:0]   pend_lvl
);

   logic [NUM_IRQ-1:0] set_q;
   logic [NUM_IRQ-1:0] en_q;
   logic [NUM_IRQ-1:0] active;
   logic [NUM_IRQ-1:0] mask_q [1:NUM_LEVELS];
   logic [NUM_LEVELS:1] lvl_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         set_q <= '0;
      end else if (set_we) begin
         set_q <= set_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (en_we) begin
         en_q <= en_wdata;
      end
   end

   assign active = (set_q | irq_lines) & en_q;

   for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[l] <= '0;
         end else if (mask_we && (mask_lvl == LVL_W'(l))) begin
            mask_q[l] <= mask_wdata;
         end
      end
      assign lvl_hit[l] = |(mask_q[l] & active);
   end

   // highest hitting level wins
   always_comb begin
      pend_lvl = '0;
      for (int l = 1; l <= NUM_LEVELS; l++) begin
         if (lvl_hit[l]) pend_lvl = LVL_W'(l);
      end
   end

   // R8: an enable-only write keeps the pending vector
   assert_set_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_we && !set_we) |=> $stable(set_q));

endmodule

// File: rtl/irq_vec_reloc.sv
module irq_vec_reloc #(
   parameter int          ADDR_W    = 32,
   parameter bit          RELOC_EN  = 1'b1,
   parameter logic [31:0] DEF_VBASE = 32'h0000_1000
) (
   input  logic [ADDR_W-1:0] vbase,
   input  logic [ADDR_W-1:0] vec_in,
   output logic [ADDR_W-1:0] vec_out
);

   localparam logic [ADDR_W-1:0] DEF_BASE = ADDR_W'(DEF_VBASE);

   if (RELOC_EN) begin : g_reloc
      assign vec_out = vec_in - DEF_BASE + vbase;
   end else begin : g_fixed
      logic unused_vbase;
      assign unused_vbase = ^vbase;
      assign vec_out      = vec_in;
   end

endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank import irq_entry_pkg::*; #(
   parameter int ADDR_W     = 32,
   parameter int NUM_LEVELS = 4,
   parameter int LVL_W      = 3,
   parameter bit HAS_DEPC   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_we,
   input  logic [LVL_W-1:0]  hi_lvl,
   input  logic              lo_epc_we,
   input  logic              depc_we,
   input  logic [ADDR_W-1:0] pc,
   input  ps_t               ps_old,
   input  logic [LVL_W-1:0]  rd_lvl,
   output logic [ADDR_W-1:0] rd_epc,
   output ps_t               rd_eps,
   output logic [ADDR_W-1:0] depc
);

   logic [ADDR_W-1:0] epc_q [1:NUM_LEVELS];
   ps_t               eps_q [2:NUM_LEVELS];

   for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_epc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            epc_q[l] <= '0;
         end else if ((hi_we && (hi_lvl == LVL_W'(l))) || ((l == 1) && lo_epc_we)) begin
            epc_q[l] <= pc;
         end
      end
   end

   for (genvar l = 2; l <= NUM_LEVELS; l++) begin : g_eps
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            eps_q[l] <= '0;
         end else if (hi_we && (hi_lvl == LVL_W'(l))) begin
            eps_q[l] <= ps_old;
         end
      end
   end

   if (HAS_DEPC) begin : g_depc
      logic [ADDR_W-1:0] depc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            depc_q <= '0;
         end else if (depc_we) begin
            depc_q <= pc;
         end
      end
      assign depc = depc_q;
   end else begin : g_no_depc
      logic unused_depc_we;
      assign unused_depc_we = depc_we;
      assign depc           = '0;
   end

   always_comb begin
      rd_epc = '0;
      rd_eps = '0;
      for (int l = 1; l <= NUM_LEVELS; l++) begin
         if (rd_lvl == LVL_W'(l)) rd_epc = epc_q[l];
      end
      for (int l = 2; l <= NUM_LEVELS; l++) begin
         if (rd_lvl == LVL_W'(l)) rd_eps = eps_q[l];
      end
   end

   // R7: the double-exception path never touches saved PC 1
   assert_depc_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (depc_we && !lo_epc_we && !(hi_we && hi_lvl == LVL_W'(1))) |=> $stable(epc_q[1]));

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl import irq_entry_pkg::*; #(
   parameter int          NUM_IRQ        = 8,
   parameter int          NUM_LEVELS     = 4,
   parameter int          ADDR_W         = 32,
   parameter logic [31:0] DEF_VBASE      = 32'h0000_1000,
   parameter bit          RELOC_EN       = 1'b1,
   parameter bit          HAS_DEPC       = 1'b1,
   parameter int          EXCM_LVL       = 1,
   parameter logic [31:0] LVL_VEC_OFF    = 32'h180,
   parameter logic [31:0] LVL_VEC_STRIDE = 32'h40,
   parameter logic [31:0] KRN_VEC_OFF    = 32'h300,
   parameter logic [31:0] USR_VEC_OFF    = 32'h340,
   parameter logic [31:0] DBL_VEC_OFF    = 32'h3C0,
   localparam int         LVL_W          = $clog2(NUM_LEVELS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_lines,
   input  logic               set_we,
   input  logic [NUM_IRQ-1:0] set_wdata,
   input  logic               en_we,
   input  logic [NUM_IRQ-1:0] en_wdata,
   input  logic               mask_we,
   input  logic [LVL_W-1:0]   mask_lvl,
   input  logic [NUM_IRQ-1:0] mask_wdata,
   input  logic               vbase_we,
   input  logic [ADDR_W-1:0]  vbase_wdata,
   input  logic               ps_we,
   input  logic [3:0]         ps_wlevel,
   input  logic               ps_wexcm,
   input  logic               ps_wum,
   input  logic [ADDR_W-1:0]  core_pc,
   input  logic               wfi_req,
   input  logic [3:0]         wfi_level,
   input  logic [LVL_W-1:0]   rd_lvl,
   output logic               taken,
   output logic [ADDR_W-1:0]  redirect_pc,
   output logic               halted,
   output logic [LVL_W-1:0]   pend_level,
   output logic [3:0]         ps_level,
   output logic               ps_excm,
   output logic               ps_um,
   output logic [5:0]         exc_cause,
   output logic [ADDR_W-1:0]  depc,
   output logic [ADDR_W-1:0]  rd_epc,
   output logic [5:0]         rd_eps
);

   localparam logic [PS_LVL_W-1:0] EXCM_FLOOR = PS_LVL_W'(EXCM_LVL);
   localparam logic [ADDR_W-1:0]   BASE_A     = ADDR_W'(DEF_VBASE);
   localparam logic [ADDR_W-1:0]   KRN_VEC    = BASE_A + ADDR_W'(KRN_VEC_OFF);
   localparam logic [ADDR_W-1:0]   USR_VEC    = BASE_A + ADDR_W'(USR_VEC_OFF);
   localparam logic [ADDR_W-1:0]   DBL_VEC    = BASE_A + ADDR_W'(DBL_VEC_OFF);

   if (NUM_LEVELS < 2 || NUM_LEVELS > 15) begin : g_bad_levels
      $error("NUM_LEVELS must lie in 2..15");
   end
   if (NUM_IRQ < 1) begin : g_bad_irq
      $error("NUM_IRQ must be at least 1");
   end
   if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 16..32");
   end
   if (EXCM_LVL < 0 || EXCM_LVL > NUM_LEVELS) begin : g_bad_excm
      $error("EXCM_LVL must lie in 0..NUM_LEVELS");
   end

   ps_t               ps_q;
   logic [CAUSE_W-1:0] cause_q;
   logic [ADDR_W-1:0] vbase_q;
   logic              halted_q;
   logic              taken_q;
   logic [ADDR_W-1:0] redir_q;

   logic [LVL_W-1:0]    pend_lvl;
   logic [PS_LVL_W-1:0] pend_ext;
   logic                accept_cur;
   logic                accept_wfi;
   logic                fire;
   entry_e              kind;
   logic [ADDR_W-1:0]   vec_raw;
   logic [ADDR_W-1:0]   vec_reloc;
   ps_t                 rd_eps_s;

   irq_pend_unit #(
      .NUM_IRQ    (NUM_IRQ),
      .NUM_LEVELS (NUM_LEVELS),
      .LVL_W      (LVL_W)
   ) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_lines  (irq_lines),
      .set_we     (set_we),
      .set_wdata  (set_wdata),
      .en_we      (en_we),
      .en_wdata   (en_wdata),
      .mask_we    (mask_we),
      .mask_lvl   (mask_lvl),
      .mask_wdata (mask_wdata),
      .pend_lvl   (pend_lvl)
   );

   assign pend_ext   = PS_LVL_W'(pend_lvl);
   assign accept_cur = (pend_lvl != '0) &&
                       (pend_ext > eff_level(ps_q.lvl, ps_q.excm, EXCM_FLOOR));
   assign accept_wfi = (pend_lvl != '0) &&
                       (pend_ext > eff_level(wfi_level, ps_q.excm, EXCM_FLOOR));

   // a wait request owns its edge; entry waits one cycle
   assign fire = accept_cur && !wfi_req;

   always_comb begin
      kind = ENT_NONE;
      if (fire) kind = (pend_lvl > LVL_W'(1)) ? ENT_HIGH : ENT_LOW;
   end

   always_comb begin
      unique case (kind)
         ENT_HIGH: vec_raw = BASE_A + ADDR_W'(LVL_VEC_OFF) +
                             ADDR_W'(pend_lvl) * ADDR_W'(LVL_VEC_STRIDE);
         ENT_LOW:  vec_raw = ps_q.excm ? DBL_VEC : (ps_q.um ? USR_VEC : KRN_VEC);
         default:  vec_raw = KRN_VEC;
      endcase
   end

   irq_vec_reloc #(
      .ADDR_W    (ADDR_W),
      .RELOC_EN  (RELOC_EN),
      .DEF_VBASE (DEF_VBASE)
   ) u_reloc (
      .vbase   (vbase_q),
      .vec_in  (vec_raw),
      .vec_out (vec_reloc)
   );

   irq_save_bank #(
      .ADDR_W     (ADDR_W),
      .NUM_LEVELS (NUM_LEVELS),
      .LVL_W      (LVL_W),
      .HAS_DEPC   (HAS_DEPC)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .hi_we     (kind == ENT_HIGH),
      .hi_lvl    (pend_lvl),
      .lo_epc_we ((kind == ENT_LOW) && !(ps_q.excm && HAS_DEPC)),
      .depc_we   ((kind == ENT_LOW) && ps_q.excm && HAS_DEPC),
      .pc        (core_pc),
      .ps_old    (ps_q),
      .rd_lvl    (rd_lvl),
      .rd_epc    (rd_epc),
      .rd_eps    (rd_eps_s),
      .depc      (depc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_q <= '0;
      end else if (wfi_req) begin
         ps_q.lvl <= wfi_level;
      end else if (kind == ENT_HIGH) begin
         ps_q.lvl  <= pend_ext;
         ps_q.excm <= 1'b1;
      end else if (kind == ENT_LOW) begin
         ps_q.excm <= 1'b1;
      end else if (ps_we) begin
         ps_q.lvl  <= ps_wlevel;
         ps_q.excm <= ps_wexcm;
         ps_q.um   <= ps_wum;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= '0;
      end else if (kind == ENT_LOW) begin
         cause_q <= CAUSE_LEVEL1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vbase_q <= BASE_A;
      end else if (vbase_we) begin
         vbase_q <= vbase_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
         taken_q  <= 1'b0;
         redir_q  <= '0;
      end else begin
         taken_q <= fire;
         if (fire) redir_q <= vec_reloc;
         if (wfi_req)   halted_q <= !accept_wfi;
         else if (fire) halted_q <= 1'b0;
      end
   end

   assign taken       = taken_q;
   assign redirect_pc = redir_q;
   assign halted      = halted_q;
   assign pend_level  = pend_lvl;
   assign ps_level    = ps_q.lvl;
   assign ps_excm     = ps_q.excm;
   assign ps_um       = ps_q.um;
   assign exc_cause   = cause_q;
   assign rd_eps      = rd_eps_s;

   assert_high_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == ENT_HIGH) |=> (taken_q && ps_q.excm && ps_q.lvl == $past(pend_ext)));

   assert_entry_sets_excm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      taken_q |-> ps_q.excm);

   assert_wfi_no_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wfi_req |=> (!taken_q && ps_q.lvl == $past(wfi_level)));

   assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_q && !accept_cur) |=> !taken_q);

   assert_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_q && accept_cur && !wfi_req) |=> (!halted_q && taken_q));

   assert_level_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_ext <= ps_q.lvl) |=> !taken_q);

endmodule

// File: tb/irq_entry_ctrl_tb.sv
`timescale 1ns/1ps
module irq_entry_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  irq_lines, set_wdata, en_wdata, mask_wdata;
   logic        set_we, en_we, mask_we, vbase_we, ps_we, ps_wexcm, ps_wum, wfi_req;
   logic [2:0]  mask_lvl, rd_lvl;
   logic [31:0] vbase_wdata, core_pc;
   logic [3:0]  ps_wlevel, wfi_level;

   logic        taken, halted, ps_excm, ps_um;
   logic [31:0] redirect_pc, depc, rd_epc;
   logic [2:0]  pend_level;
   logic [3:0]  ps_level;
   logic [5:0]  exc_cause, rd_eps;

   logic        taken_d, halted_d, ps_excm_d, ps_um_d;
   logic [31:0] redirect_pc_d, depc_d, rd_epc_d;
   logic [2:0]  pend_level_d;
   logic [3:0]  ps_level_d;
   logic [5:0]  exc_cause_d, rd_eps_d;

   int total = 0;
   int fails = 0;

   always #2 clk = ~clk;

   irq_entry_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
      .set_we(set_we), .set_wdata(set_wdata), .en_we(en_we), .en_wdata(en_wdata),
      .mask_we(mask_we), .mask_lvl(mask_lvl), .mask_wdata(mask_wdata),
      .vbase_we(vbase_we), .vbase_wdata(vbase_wdata),
      .ps_we(ps_we), .ps_wlevel(ps_wlevel), .ps_wexcm(ps_wexcm), .ps_wum(ps_wum),
      .core_pc(core_pc), .wfi_req(wfi_req), .wfi_level(wfi_level), .rd_lvl(rd_lvl),
      .taken(taken), .redirect_pc(redirect_pc), .halted(halted), .pend_level(pend_level),
      .ps_level(ps_level), .ps_excm(ps_excm), .ps_um(ps_um), .exc_cause(exc_cause),
      .depc(depc), .rd_epc(rd_epc), .rd_eps(rd_eps)
   );

   irq_entry_ctrl #(.EXCM_LVL(0)) u_dut_dbl (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
      .set_we(set_we), .set_wdata(set_wdata), .en_we(en_we), .en_wdata(en_wdata),
      .mask_we(mask_we), .mask_lvl(mask_lvl), .mask_wdata(mask_wdata),
      .vbase_we(vbase_we), .vbase_wdata(vbase_wdata),
      .ps_we(ps_we), .ps_wlevel(ps_wlevel), .ps_wexcm(ps_wexcm), .ps_wum(ps_wum),
      .core_pc(core_pc), .wfi_req(wfi_req), .wfi_level(wfi_level), .rd_lvl(rd_lvl),
      .taken(taken_d), .redirect_pc(redirect_pc_d), .halted(halted_d),
      .pend_level(pend_level_d), .ps_level(ps_level_d), .ps_excm(ps_excm_d),
      .ps_um(ps_um_d), .exc_cause(exc_cause_d), .depc(depc_d), .rd_epc(rd_epc_d),
      .rd_eps(rd_eps_d)
   );

   task automatic report();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr_ps(input logic [3:0] lvl, input logic excm, input logic um);
      ps_we = 1'b1; ps_wlevel = lvl; ps_wexcm = excm; ps_wum = um;
      tick();
      ps_we = 1'b0;
   endtask

   task automatic wr_mask(input logic [2:0] lvl, input logic [7:0] val);
      mask_we = 1'b1; mask_lvl = lvl; mask_wdata = val;
      tick();
      mask_we = 1'b0;
   endtask

   task automatic drive_irq(input logic [7:0] en, input logic [7:0] set, input logic [7:0] lines);
      en_we = 1'b1; en_wdata = en; set_we = 1'b1; set_wdata = set; irq_lines = lines;
      tick();
      en_we = 1'b0; set_we = 1'b0;
   endtask

   task automatic clr();
      drive_irq(8'h00, 8'h00, 8'h00);
      wr_ps(4'd0, 1'b0, 1'b0);
      tick();
   endtask

   task automatic t_reset();
      chk("R1 taken", taken, 0);
      chk("R1 halted", halted, 0);
      chk("R1 ps_level", ps_level, 0);
      chk("R1 excm/um", {ps_excm, ps_um}, 0);
      chk("R1 pend_level", pend_level, 0);
      chk("R1 redirect", redirect_pc, 0);
   endtask

   task automatic t_mask_ignore();
      // R2: table writes for level 0 or level 5 do nothing
      wr_mask(3'd0, 8'hFF);
      wr_mask(3'd5, 8'hFF);
      drive_irq(8'hFF, 8'hFF, 8'h00);
      chk("R2 bad table index ignored", pend_level, 0);
      clr();
   endtask

   task automatic t_arbitrate();
      clr();
      core_pc = 32'h100; rd_lvl = 3'd3;
      drive_irq(8'h3F, 8'h50, 8'h05);
      chk("R2 highest enabled level", pend_level, 3);
      chk("R4 no entry before decision edge", taken, 0);
      tick();
      chk("R4 taken strobe", taken, 1);
      chk("R5 level-3 vector", redirect_pc, 32'h1240);
      chk("R4 status level", ps_level, 3);
      chk("R4 exception mode", ps_excm, 1);
      chk("R4 saved PC 3", rd_epc, 32'h100);
      chk("R4 saved status 3", rd_eps, 6'h00);
      tick();
      chk("R3 equal level not retaken", taken, 0);
      clr();
   endtask

   task automatic t_lines_and_ports();
      clr();
      drive_irq(8'h0C, 8'h00, 8'h08);
      chk("R8 line feeds candidate", pend_level, 2);
      irq_lines = 8'h00;
      #1;
      chk("R8 line not stored", pend_level, 0);
      wr_ps(4'd7, 1'b0, 1'b0);
      set_we = 1'b1; set_wdata = 8'hC0;
      tick();
      set_we = 1'b0;
      chk("R8 set write keeps enable", pend_level, 0);
      en_we = 1'b1; en_wdata = 8'hC0;
      tick();
      en_we = 1'b0;
      chk("R8 enable write keeps pending", pend_level, 4);
      clr();
   endtask

   task automatic t_level_gate();
      clr();
      wr_ps(4'd3, 1'b0, 1'b0);
      core_pc = 32'h180; rd_lvl = 3'd4;
      drive_irq(8'hFF, 8'h30, 8'h00);
      tick();
      chk("R3 equal level blocked", taken, 0);
      chk("R3 level kept", ps_level, 3);
      set_we = 1'b1; set_wdata = 8'hF0;
      tick();
      set_we = 1'b0;
      tick();
      chk("R3 higher level taken", taken, 1);
      chk("R5 level-4 vector", redirect_pc, 32'h1280);
      chk("R4 saved status 4", rd_eps, 6'h03);
      chk("R4 saved PC 4", rd_epc, 32'h180);
      clr();
   endtask

   task automatic t_level1(input logic um, input logic [31:0] pc, input logic [31:0] vec);
      clr();
      wr_ps(4'd0, 1'b0, um);
      core_pc = pc; rd_lvl = 3'd1;
      drive_irq(8'h01, 8'h00, 8'h01);
      tick();
      chk("R6 level-1 taken", taken, 1);
      chk(um ? "R6 user vector" : "R6 kernel vector", redirect_pc, vec);
      chk("R6 cause code", exc_cause, 4);
      chk("R6 saved PC 1", rd_epc, pc);
      chk("R6 level unchanged, excm set", {ps_level, ps_excm}, {4'd0, 1'b1});
      tick();
      chk("R3 exception mode masks level 1", taken, 0);
      clr();
   endtask

   task automatic t_double();
      clr();
      wr_ps(4'd0, 1'b1, 1'b0);
      core_pc = 32'h300; rd_lvl = 3'd1;
      drive_irq(8'h01, 8'h00, 8'h01);
      tick();
      chk("R7 double entry taken", taken_d, 1);
      chk("R7 double vector", redirect_pc_d, 32'h13C0);
      chk("R7 depc holds PC", depc_d, 32'h300);
      chk("R7 saved PC 1 untouched", rd_epc_d, 32'h204);
      chk("R7 cause code", exc_cause_d, 4);
      chk("R3 masked under exception mode", taken, 0);
      clr();
   endtask

   task automatic t_wfi_pending();
      clr();
      wr_ps(4'd3, 1'b0, 1'b0);
      drive_irq(8'hFF, 8'h30, 8'h00);
      wfi_req = 1'b1; wfi_level = 4'd0;
      tick();
      wfi_req = 1'b0;
      chk("R9 wait sets level", ps_level, 0);
      chk("R9 no entry on wait edge", taken, 0);
      chk("R9 pending keeps core running", halted, 0);
      tick();
      chk("R9 entry follows wait", taken, 1);
      chk("R9 entry level", ps_level, 3);
      clr();
   endtask

   task automatic t_wfi_halt();
      clr();
      wr_ps(4'd3, 1'b0, 1'b0);
      drive_irq(8'h0C, 8'h00, 8'h04);
      wfi_req = 1'b1; wfi_level = 4'd2;
      tick();
      wfi_req = 1'b0;
      chk("R9 halt when masked", halted, 1);
      chk("R9 level from wait", ps_level, 2);
      tick();
      tick();
      chk("R10 stays halted", {halted, taken}, 2'b10);
      drive_irq(8'h3C, 8'h00, 8'h14);
      chk("R10 not yet woken", halted, 1);
      tick();
      chk("R10 wake clears halt", halted, 0);
      chk("R10 wake entry", taken, 1);
      chk("R10 wake vector", redirect_pc, 32'h1240);
      clr();
   endtask

   task automatic t_reloc();
      clr();
      vbase_we = 1'b1; vbase_wdata = 32'h4000_0000;
      tick();
      vbase_we = 1'b0;
      drive_irq(8'h0C, 8'h04, 8'h00);
      tick();
      chk("R11 relocated level-2 vector", redirect_pc, 32'h4000_0200);
      clr();
   endtask

   initial begin
      rst_n = 1'b0;
      irq_lines = 0; set_we = 0; set_wdata = 0; en_we = 0; en_wdata = 0;
      mask_we = 0; mask_lvl = 0; mask_wdata = 0; vbase_we = 0; vbase_wdata = 0;
      ps_we = 0; ps_wlevel = 0; ps_wexcm = 0; ps_wum = 0;
      core_pc = 0; wfi_req = 0; wfi_level = 0; rd_lvl = 0;
      tick();
      tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_mask_ignore();
      wr_mask(3'd1, 8'h03);
      wr_mask(3'd2, 8'h0C);
      wr_mask(3'd3, 8'h30);
      wr_mask(3'd4, 8'hC0);
      t_arbitrate();
      t_lines_and_ports();
      t_level_gate();
      t_level1(1'b1, 32'h200, 32'h1340);
      t_level1(1'b0, 32'h204, 32'h1300);
      t_double();
      t_wfi_pending();
      t_wfi_halt();
      t_reloc();
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog expired");
      report();
   end

endmodule